// File: doc/BRIEF.md
# Repeated String Operation Sequencer

This block runs one repeated string primitive over a byte-addressed memory without processor involvement. A single start command selects the primitive (move, compare, scan, load or store), the element size (byte or word), a repeat mode and a direction. The command also loads a source pointer, a destination pointer, a repeat count and an accumulator. The sequencer then issues one memory beat at a time on a request/acknowledge port. After each element it decrements the count and steps the pointers that the primitive used.

Each pointer is an offset into its own area. The memory address is the area base plus the zero-extended offset. Compare and scan set a zero flag, and in the two conditional repeat modes they end the run early on the first equal or unequal element. When the run ends, a one-cycle done pulse is issued. The final pointers, count, accumulator and zero flag stay on the outputs until the next command.

Top module: `strop_seq`

## Requirements
- R1: Operation code 0 (move) reads each element at src_base+src_ptr and writes it to dst_base+dst_ptr. A word is two bytes, little-endian: the low byte is at the lower address and sits in data bits 7:0. A byte travels in bits 7:0.
- R2: After each element, a used pointer steps by 1 (byte, wide=0) or 2 (word, wide=1), upward when dir=0 and downward when dir=1, modulo 2^16. Move and compare step both pointers. Scan and store step only the destination pointer. Load steps only the source pointer.
- R3: The count decrements by one per element. In count-only repeat (rep_mode 0, or 3) the run processes exactly count_in elements and ends with count 0.
- R4: Operation code 1 (compare) reads the source element, then the destination element, and never writes. The zero flag becomes 1 when the two are equal in the selected width and 0 otherwise.
- R5: Operation code 2 (scan) compares the accumulator (bits 7:0 only for bytes) with the element at the destination pointer. It never writes and sets the zero flag the same way.
- R6: With rep_mode 2 (repeat while unequal), a compare or scan run ends after the first element that compares equal, with the zero flag 1 and the count showing the elements still left.
- R7: With rep_mode 1 (repeat while equal), a compare or scan run ends after the first element that compares unequal, with the zero flag 0.
- R8: Operation code 3 (load) copies the source element into the accumulator (a byte replaces bits 7:0 only). Operation code 4 (store) writes the accumulator (bits 7:0 for bytes) to the destination. Neither changes the zero flag.
- R9: A start with count_in 0, or with an operation code above 4, ends with done in the next cycle and makes no memory access. The outputs show the loaded pointers, count and accumulator, and the zero flag is unchanged.
- R10: Done is high for exactly one cycle per run. While the block is idle, the pointer, count and accumulator outputs hold. A start while busy is ignored.
- R11: A memory request holds its address and direction until it is acknowledged, for any number of wait cycles.
- R12: During reset, busy, done, mem_req and the zero flag are 0, and the pointers, count and accumulator are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Command strobe, taken when idle |
| op | input | 3 | Primitive: 0 move, 1 compare, 2 scan, 3 load, 4 store |
| wide | input | 1 | 1 word elements, 0 byte elements |
| rep_mode | input | 2 | 0 count only, 1 while equal, 2 while unequal |
| dir | input | 1 | 0 step up, 1 step down |
| src_base | input | 20 | Base address of the source area |
| dst_base | input | 20 | Base address of the destination area |
| src_ptr_in | input | 16 | Initial source offset |
| dst_ptr_in | input | 16 | Initial destination offset |
| count_in | input | 16 | Repeat count |
| acc_in | input | 16 | Initial accumulator |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_wide | output | 1 | Beat is a word |
| mem_addr | output | 20 | Byte address of the beat |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Beat completes on a cycle with mem_req and mem_ack |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| src_ptr | output | 16 | Current source offset |
| dst_ptr | output | 16 | Current destination offset |
| count | output | 16 | Remaining count |
| acc | output | 16 | Accumulator |
| zf | output | 1 | Zero flag from the last compare or scan |

## Verification
A wrong step size or direction shows up at the memory port on the second element. The address of that beat moves off by one or two bytes, and the final pointer outputs miss by a multiple of the element count. A faulty termination decision, or a lost count decrement, shows up as a run that is too long or too short. Such a run gives extra or missing beats, a wrong final count and a stale zero flag, all visible at the done pulse. A corrupted element register appears as a wrong byte in the destination area or in the accumulator as soon as the run ends.

// File: rtl/strop_pkg.sv
// Shared types for the string sequencer: primitive codes, repeat modes,
// control states and the helpers that map a primitive to its first beat
// and to the pointers it steps. Assumes 3-bit primitive codes.
package strop_pkg;

    typedef enum logic [2:0] {
        OP_MOVE  = 3'd0,
        OP_CMP   = 3'd1,
        OP_SCAN  = 3'd2,
        OP_LOAD  = 3'd3,
        OP_STORE = 3'd4
    } op_e;

    localparam logic [1:0] RPT_WHILE_EQ = 2'd1;
    localparam logic [1:0] RPT_WHILE_NE = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RD_SRC = 3'd1,
        ST_RD_DST = 3'd2,
        ST_WR_DST = 3'd3,
        ST_STEP   = 3'd4,
        ST_DONE   = 3'd5
    } state_e;

    // First memory beat of an element for a primitive
    function automatic state_e first_beat(input op_e code);
        case (code)
            OP_SCAN:  first_beat = ST_RD_DST;
            OP_STORE: first_beat = ST_WR_DST;
            default:  first_beat = ST_RD_SRC;
        endcase
    endfunction

    // Primitive touches the source area
    function automatic logic uses_src(input op_e code);
        uses_src = (code == OP_MOVE) || (code == OP_CMP) || (code == OP_LOAD);
    endfunction

    // Primitive touches the destination area
    function automatic logic uses_dst(input op_e code);
        uses_dst = (code != OP_LOAD);
    endfunction

    // Primitive produces a zero flag
    function automatic logic sets_flag(input op_e code);
        sets_flag = (code == OP_CMP) || (code == OP_SCAN);
    endfunction

endpackage

// File: rtl/strop_ptr_step.sv
// Pointer stepper: moves an offset by one element in the chosen direction.
// Assumes offsets wrap modulo 2^PTR_W; a disabled stepper passes through.
module strop_ptr_step #(
    parameter int PTR_W = 16
) (
    input  logic [PTR_W-1:0] ptr_in,
    input  logic             en,
    input  logic             dir,
    input  logic             wide,
    output logic [PTR_W-1:0] ptr_out
);
    localparam logic [PTR_W-1:0] STEP_BYTE = PTR_W'(1);
    localparam logic [PTR_W-1:0] STEP_WORD = PTR_W'(2);

    logic [PTR_W-1:0] inc;

    // Element size picks the stride; direction picks add or subtract
    always_comb begin
        inc = wide ? STEP_WORD : STEP_BYTE;
        if (!en)
            ptr_out = ptr_in;
        else if (dir)
            ptr_out = ptr_in - inc;
        else
            ptr_out = ptr_in + inc;
    end
endmodule

// File: rtl/strop_agen.sv
// Address former: area base plus zero-extended offset.
// Assumes ADDR_W >= PTR_W; the equal-width variant is a plain add.
module strop_agen #(
    parameter int PTR_W  = 16,
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [PTR_W-1:0]  ofs,
    output logic [ADDR_W-1:0] addr
);
    localparam int PAD_W = ADDR_W - PTR_W;

    generate
        if (PAD_W > 0) begin : g_pad
            // Widen the offset before the add
            always_comb addr = base + {{PAD_W{1'b0}}, ofs};
        end else begin : g_flat
            // Widths match, add directly
            always_comb addr = base + ofs[ADDR_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/strop_match.sv
// Element comparator: equality over the full word or over the low byte.
// Assumes DATA_W is even; the byte is the low half.
module strop_match #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    input  logic              wide,
    output logic              equal
);
    localparam int HALF_W = DATA_W / 2;

    // Compare in the selected element width
    always_comb begin
        if (wide)
            equal = (lhs == rhs);
        else
            equal = (lhs[HALF_W-1:0] == rhs[HALF_W-1:0]);
    end
endmodule

// File: rtl/strop_seq.sv
// String sequencer top: takes a command, then walks elements one memory beat
// at a time, stepping pointers and the count in a dedicated step cycle and
// ending on count exhaustion or on a compare condition. Assumes the memory
// holds rdata valid in the cycle it raises ack, and little-endian words.
module strop_seq
    import strop_pkg::*;
#(
    parameter int PTR_W  = 16,
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic              wide,
    input  logic [1:0]        rep_mode,
    input  logic              dir,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic [PTR_W-1:0]  src_ptr_in,
    input  logic [PTR_W-1:0]  dst_ptr_in,
    input  logic [CNT_W-1:0]  count_in,
    input  logic [DATA_W-1:0] acc_in,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_wide,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              busy,
    output logic              done,
    output logic [PTR_W-1:0]  src_ptr,
    output logic [PTR_W-1:0]  dst_ptr,
    output logic [CNT_W-1:0]  count,
    output logic [DATA_W-1:0] acc,
    output logic              zf
);
    localparam int HALF_W = DATA_W / 2;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    state_e            state_q;
    op_e               op_q;
    logic              wide_q;
    logic [1:0]        rep_q;
    logic              dir_q;
    logic [ADDR_W-1:0] sbase_q;
    logic [ADDR_W-1:0] dbase_q;
    logic [PTR_W-1:0]  sptr_q;
    logic [PTR_W-1:0]  dptr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] acc_q;
    logic              zf_q;
    logic [DATA_W-1:0] elem_src_q;
    logic [DATA_W-1:0] elem_dst_q;

    logic [ADDR_W-1:0] src_addr;
    logic [ADDR_W-1:0] dst_addr;
    logic [PTR_W-1:0]  sptr_next;
    logic [PTR_W-1:0]  dptr_next;
    logic [DATA_W-1:0] cmp_lhs;
    logic              elem_equal;
    logic [CNT_W-1:0]  cnt_dec;
    logic              stop_early;
    logic              run_end;
    logic              beat_done;
    logic              cmd_valid;
    op_e               op_cmd;

    // Address formation for each area
    strop_agen #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) i_agen_src (
        .base (sbase_q),
        .ofs  (sptr_q),
        .addr (src_addr)
    );

    strop_agen #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) i_agen_dst (
        .base (dbase_q),
        .ofs  (dptr_q),
        .addr (dst_addr)
    );

    // Pointer steppers, enabled by the areas the primitive touches
    strop_ptr_step #(.PTR_W(PTR_W)) i_step_src (
        .ptr_in  (sptr_q),
        .en      (uses_src(op_q)),
        .dir     (dir_q),
        .wide    (wide_q),
        .ptr_out (sptr_next)
    );

    strop_ptr_step #(.PTR_W(PTR_W)) i_step_dst (
        .ptr_in  (dptr_q),
        .en      (uses_dst(op_q)),
        .dir     (dir_q),
        .wide    (wide_q),
        .ptr_out (dptr_next)
    );

    // Compare source element (compare) or accumulator (scan) to destination element
    always_comb cmp_lhs = (op_q == OP_CMP) ? elem_src_q : acc_q;

    strop_match #(.DATA_W(DATA_W)) i_match (
        .lhs   (cmp_lhs),
        .rhs   (elem_dst_q),
        .wide  (wide_q),
        .equal (elem_equal)
    );

    // Command decode: only codes 0..4 carry work
    always_comb begin
        cmd_valid = (op <= 3'd4);
        op_cmd    = cmd_valid ? op_e'(op) : OP_MOVE;
    end

    // End-of-element decision
    always_comb begin
        cnt_dec    = cnt_q - CNT_ONE;
        stop_early = sets_flag(op_q) &&
                     (((rep_q == RPT_WHILE_EQ) && !elem_equal) ||
                      ((rep_q == RPT_WHILE_NE) &&  elem_equal));
        run_end    = (cnt_dec == '0) || stop_early;
    end

    // Memory port drive from the current state
    always_comb begin
        mem_req   = (state_q == ST_RD_SRC) || (state_q == ST_RD_DST) || (state_q == ST_WR_DST);
        mem_we    = (state_q == ST_WR_DST);
        mem_wide  = wide_q;
        mem_addr  = (state_q == ST_RD_SRC) ? src_addr : dst_addr;
        mem_wdata = (op_q == OP_MOVE) ? elem_src_q : acc_q;
        if (!wide_q)
            mem_wdata = {{(DATA_W-HALF_W){1'b0}}, mem_wdata[HALF_W-1:0]};
        beat_done = mem_req && mem_ack;
    end

    // Control state and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            op_q       <= OP_MOVE;
            wide_q     <= 1'b0;
            rep_q      <= 2'd0;
            dir_q      <= 1'b0;
            sbase_q    <= '0;
            dbase_q    <= '0;
            sptr_q     <= '0;
            dptr_q     <= '0;
            cnt_q      <= '0;
            acc_q      <= '0;
            zf_q       <= 1'b0;
            elem_src_q <= '0;
            elem_dst_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        op_q    <= op_cmd;
                        wide_q  <= wide;
                        rep_q   <= rep_mode;
                        dir_q   <= dir;
                        sbase_q <= src_base;
                        dbase_q <= dst_base;
                        sptr_q  <= src_ptr_in;
                        dptr_q  <= dst_ptr_in;
                        cnt_q   <= count_in;
                        acc_q   <= acc_in;
                        if (!cmd_valid || (count_in == '0))
                            state_q <= ST_DONE;
                        else
                            state_q <= first_beat(op_cmd);
                    end
                end
                ST_RD_SRC: begin
                    if (beat_done) begin
                        elem_src_q <= mem_rdata;
                        if (op_q == OP_CMP)
                            state_q <= ST_RD_DST;
                        else if (op_q == OP_MOVE)
                            state_q <= ST_WR_DST;
                        else
                            state_q <= ST_STEP;
                    end
                end
                ST_RD_DST: begin
                    if (beat_done) begin
                        elem_dst_q <= mem_rdata;
                        state_q    <= ST_STEP;
                    end
                end
                ST_WR_DST: begin
                    if (beat_done)
                        state_q <= ST_STEP;
                end
                ST_STEP: begin
                    sptr_q <= sptr_next;
                    dptr_q <= dptr_next;
                    cnt_q  <= cnt_dec;
                    if (sets_flag(op_q))
                        zf_q <= elem_equal;
                    if (op_q == OP_LOAD) begin
                        if (wide_q)
                            acc_q <= elem_src_q;
                        else
                            acc_q <= {acc_q[DATA_W-1:HALF_W], elem_src_q[HALF_W-1:0]};
                    end
                    state_q <= run_end ? ST_DONE : first_beat(op_q);
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Status and result outputs
    always_comb begin
        busy    = (state_q != ST_IDLE);
        done    = (state_q == ST_DONE);
        src_ptr = sptr_q;
        dst_ptr = dptr_q;
        count   = cnt_q;
        acc     = acc_q;
        zf      = zf_q;
    end

    // Assertions guarding the control and memory port
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                        // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(src_ptr) && $stable(dst_ptr) && $stable(count) && $stable(acc)));  // R10
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));  // R11
    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && (op_q == OP_CMP)) |-> !mem_we);                             // R4
    AST_SCAN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && (op_q == OP_SCAN)) |-> !mem_we);                            // R5
    AST_ZERO_COUNT_IDLE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (count_in == '0)) |=> (done && !mem_req));          // R9
    AST_WORK_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (count != '0));                                             // R3
    AST_FLAG_ONLY_ON_COMPARE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sets_flag(op_q)) |=> $stable(zf));                            // R8

endmodule

// File: tb/test_strop_seq.sv
`timescale 1ns/1ps
module test_strop_seq;
    logic        clk;
    logic        rst_n;
    logic        start;
    logic [2:0]  op;
    logic        wide;
    logic [1:0]  rep_mode;
    logic        dir;
    logic [19:0] src_base;
    logic [19:0] dst_base;
    logic [15:0] src_ptr_in;
    logic [15:0] dst_ptr_in;
    logic [15:0] count_in;
    logic [15:0] acc_in;
    logic        mem_req;
    logic        mem_we;
    logic        mem_wide;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        mem_ack;
    logic        busy;
    logic        done;
    logic [15:0] src_ptr;
    logic [15:0] dst_ptr;
    logic [15:0] count;
    logic [15:0] acc;
    logic        zf;

    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    int total = 0;
    int bad = 0;
    int n_beats = 0;
    int hs_err = 0;
    int mem_lat = 0;
    logic exp_zf = 1'b0;

    strop_seq i_strop_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wide(wide),
        .rep_mode(rep_mode), .dir(dir), .src_base(src_base), .dst_base(dst_base),
        .src_ptr_in(src_ptr_in), .dst_ptr_in(dst_ptr_in), .count_in(count_in),
        .acc_in(acc_in), .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .busy(busy), .done(done), .src_ptr(src_ptr),
        .dst_ptr(dst_ptr), .count(count), .acc(acc), .zf(zf)
    );

    initial begin
        clk = 1'b0;
        forever #4 clk = ~clk;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Memory model: serves one beat after mem_lat wait cycles, acks for one cycle
    initial begin : mem_model
        int waitc;
        bit pend;
        logic [19:0] pa;
        logic pw;
        logic [7:0] a8;
        waitc = 0;
        pend = 0;
        pa = '0;
        pw = 1'b0;
        mem_ack = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                pend = 0;
            end else if (rst_n && mem_req) begin
                if (!pend) begin
                    pend = 1;
                    pa = mem_addr;
                    pw = mem_we;
                end else if (pa != mem_addr || pw != mem_we) begin
                    hs_err++;
                end
                if (waitc < mem_lat) begin
                    waitc++;
                end else begin
                    waitc = 0;
                    a8 = mem_addr[7:0];
                    if (mem_we) begin
                        mem[a8] = mem_wdata[7:0];
                        if (mem_wide) mem[a8 + 8'd1] = mem_wdata[15:8];
                    end else begin
                        mem_rdata = mem_wide ? {mem[a8 + 8'd1], mem[a8]} : {8'h00, mem[a8]};
                    end
                    mem_ack = 1'b1;
                    n_beats++;
                end
            end
        end
    end

    function automatic logic [15:0] ref_rd(input logic [19:0] a, input bit w);
        logic [7:0] b;
        b = a[7:0];
        ref_rd = w ? {exp_mem[b + 8'd1], exp_mem[b]} : {8'h00, exp_mem[b]};
    endfunction

    task automatic ref_wr(input logic [19:0] a, input logic [15:0] v, input bit w);
        logic [7:0] b;
        b = a[7:0];
        exp_mem[b] = v[7:0];
        if (w) exp_mem[b + 8'd1] = v[15:8];
    endtask

    function automatic bit ref_eq(input logic [15:0] x, input logic [15:0] y, input bit w);
        ref_eq = w ? (x == y) : (x[7:0] == y[7:0]);
    endfunction

    task automatic run_case(input int o, input bit w, input int rp, input bit d,
                            input logic [15:0] sp0, input logic [15:0] dp0,
                            input int cnt, input logic [15:0] ac0, input int seed,
                            input int lt, input bit poke);
        logic [19:0] sb;
        logic [19:0] db;
        logic [15:0] sp;
        logic [15:0] dp;
        logic [15:0] c;
        logic [15:0] ac;
        logic [15:0] va;
        logic [15:0] vb;
        logic [15:0] inc;
        logic z;
        int nb;
        int wt;
        int mism;
        string tag;
        string ztag;
        sb = 20'h12300;
        db = 20'h00050;
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(((i >> 2) + seed) % 3);
            exp_mem[i] = mem[i];
        end
        sp = sp0; dp = dp0; c = 16'(cnt); ac = ac0; z = exp_zf; nb = 0;
        inc = w ? 16'd2 : 16'd1;
        case (o)
            0: tag = "R1";
            1: tag = "R4";
            2: tag = "R5";
            3, 4: tag = "R8";
            default: tag = "R9";
        endcase
        if (cnt == 0) tag = "R9";
        ztag = (rp == 1 && (o == 1 || o == 2)) ? "R7" :
               (rp == 2 && (o == 1 || o == 2)) ? "R6" : tag;
        // Reference model
        if (o <= 4) begin
            while (c != 16'd0) begin
                case (o)
                    0: begin va = ref_rd(sb + {4'h0, sp}, w); ref_wr(db + {4'h0, dp}, va, w); nb += 2; end
                    1: begin va = ref_rd(sb + {4'h0, sp}, w); vb = ref_rd(db + {4'h0, dp}, w);
                             z = ref_eq(va, vb, w); nb += 2; end
                    2: begin vb = ref_rd(db + {4'h0, dp}, w); z = ref_eq(ac, vb, w); nb += 1; end
                    3: begin va = ref_rd(sb + {4'h0, sp}, w); ac = w ? va : {ac[15:8], va[7:0]}; nb += 1; end
                    default: begin ref_wr(db + {4'h0, dp}, ac, w); nb += 1; end
                endcase
                if (o != 2 && o != 4) sp = d ? sp - inc : sp + inc;
                if (o != 3) dp = d ? dp - inc : dp + inc;
                c = c - 16'd1;
                if ((o == 1 || o == 2) && ((rp == 1 && !z) || (rp == 2 && z))) break;
            end
        end
        // Drive the command
        mem_lat = lt;
        n_beats = 0;
        hs_err = 0;
        @(negedge clk);
        op = 3'(o); wide = w; rep_mode = 2'(rp); dir = d;
        src_base = sb; dst_base = db; src_ptr_in = sp0; dst_ptr_in = dp0;
        count_in = 16'(cnt); acc_in = ac0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            @(negedge clk);
            op = 3'd4; src_ptr_in = 16'h0000; dst_ptr_in = 16'h0001; count_in = 16'd9;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wt = 0;
        while (!done && wt < 3000) begin
            @(negedge clk);
            wt++;
        end
        chk(done === 1'b1, "R10", "done seen", longint'(done), 1);
        chk(src_ptr === sp, "R2", "src_ptr", src_ptr, sp);
        chk(dst_ptr === dp, "R2", "dst_ptr", dst_ptr, dp);
        chk(count === c, (rp != 0 && (o == 1 || o == 2)) ? ztag : "R3", "count", count, c);
        chk(acc === ac, tag, "acc", acc, ac);
        chk(zf === z, ztag, "zf", longint'(zf), longint'(z));
        mism = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) mism++;
        chk(mism == 0, tag, "memory bytes differing", mism, 0);
        chk(n_beats == nb, (cnt == 0 || o > 4) ? "R9" : "R3", "beats", n_beats, nb);
        chk(hs_err == 0, "R11", "request changed while waiting", hs_err, 0);
        exp_zf = z;
        @(negedge clk);
        chk(done === 1'b0, "R10", "done one cycle", longint'(done), 0);
    endtask

    initial begin : stim
        int idx;
        int cnts [4];
        cnts[0] = 0; cnts[1] = 1; cnts[2] = 5; cnts[3] = 7;
        rst_n = 1'b0; start = 1'b0; op = '0; wide = 1'b0; rep_mode = '0; dir = 1'b0;
        src_base = '0; dst_base = '0; src_ptr_in = '0; dst_ptr_in = '0;
        count_in = '0; acc_in = '0;
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && mem_req === 1'b0, "R12", "busy/done/req in reset",
            {busy, done, mem_req}, 0);
        chk(zf === 1'b0 && count === 16'd0 && src_ptr === 16'd0 && dst_ptr === 16'd0 && acc === 16'd0,
            "R12", "state in reset", {count, src_ptr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        idx = 0;
        for (int o = 0; o < 5; o++)
            for (int w = 0; w < 2; w++)
                for (int d = 0; d < 2; d++)
                    for (int rp = 0; rp < 3; rp++)
                        for (int ci = 0; ci < 4; ci++) begin
                            run_case(o, w[0], rp, d[0],
                                     d ? 16'h0030 : 16'h0010, d ? 16'h0040 : 16'h0020,
                                     cnts[ci], {8'(idx % 3), 8'(idx % 3)}, idx, idx % 3, 1'b0);
                            idx++;
                        end
        // Offset wrap past the top of the pointer range (R2)
        run_case(0, 1'b1, 0, 1'b0, 16'hFFFF, 16'hFFFE, 3, 16'h0000, 1, 1, 1'b0);
        run_case(2, 1'b0, 3, 1'b1, 16'h0000, 16'h0001, 4, 16'h0002, 2, 0, 1'b0);
        // Start while busy is ignored (R10)
        run_case(0, 1'b0, 0, 1'b0, 16'h0010, 16'h0020, 4, 16'h1234, 3, 2, 1'b1);
        // Undefined operation code does no work (R9)
        run_case(6, 1'b1, 0, 1'b0, 16'h0010, 16'h0020, 3, 16'hABCD, 4, 0, 1'b0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule